// File: doc/BRIEF.md
# Scoreboard Dynamic Scheduling Controller

This block tracks hazards for a single-issue machine that feeds five functional units: one integer unit, one floating-point adder, one divider and two multipliers. Decoded instructions arrive in program order as an operation class, a destination register and two source register numbers. The controller decides when each instruction may enter a unit, when that unit may fetch its operands and when it may retire its result. Execution can therefore start and finish out of program order, while true, anti and output dependences are all honoured.

Each unit keeps a status record. The record holds a busy flag, the operation class, the destination, both sources, the unit expected to produce each source and a ready flag per source. A register-to-producer table names the unit that will next write each of the 32 registers. Execution inside a unit is modelled as a countdown of its latency. No data values, forwarding paths or renaming are present. A result is held back at write-back for as long as another unit still has to read the old contents of the target register.

Top module: `scoreboardCtl`

## Requirements
- R1: After reset, every unit is free, the producer table is empty, `instReady` is high and no read, execute-start or write-back strobe is active.
- R2: `instClass` encodes 0 = integer, 1 = add, 2 = multiply, 3 = divide. The unit codes on `issueUnit` are 1 = integer, 2 = adder, 3 = divider, 4 and 5 = multipliers. A multiply takes the lower-coded free multiplier.
- R3: An instruction with no pending producers issues in the cycle it is presented. Its unit's `readGrant` rises one cycle later and `execStart` one cycle after that. `wbGrant` comes LAT+1 cycles after `readGrant`, where LAT is 1, 4, 6 or 10 for integer, add, multiply or divide, unless a hold or contention applies. `wbReg` shows the destination during `wbGrant`.
- R4: A unit reads its operands only once no earlier active instruction will write either source. A dependent read comes in the cycle after the producer's write-back. This includes an instruction that issues in the same cycle as its producer's write-back.
- R5: An instruction whose destination is already targeted by an active instruction does not issue. `instReady` stays low and the front end stalls. Issue happens in the cycle after that producer's write-back.
- R6: An instruction whose class has no free unit stalls until a unit of that class writes back. It issues in the following cycle.
- R7: A finished unit does not write back while another unit still holds an unread source that names the finished unit's destination. It writes back in the cycle after that reader's operand read.
- R8: At most one write-back is granted per cycle. When several units are ready together, the lowest unit code wins and the others follow in later cycles.
- R9: Each issued instruction produces exactly one `readGrant`, one `execStart` and one `wbGrant` on its unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A decoded instruction is presented |
| instClass | input | 2 | Operation class (R2 encoding) |
| instDst | input | 5 | Destination register |
| instSrc1 | input | 5 | First source register |
| instSrc2 | input | 5 | Second source register |
| instReady | output | 1 | Presented instruction can issue this cycle |
| issueUnit | output | 3 | Code of the unit the instruction goes to |
| readGrant | output | 5 | Per-unit operand read grant, bit i = unit code i+1 |
| execStart | output | 5 | Per-unit first execute cycle |
| wbGrant | output | 5 | Per-unit write-back grant |
| wbReg | output | 5 | Register written by the granted unit |

## Verification
On every cycle, the assertions check the following. Write-backs are one-hot and come only from finished units. Issue never targets a busy unit or a register that is already claimed. Operand reads occur only with both producers cleared, and no write-back happens over an unread source. A unit's record must also match the class that unit serves. Only the bench scenarios can show the cycle-exact behaviour: the latency of each unit class, the exact stall length for structural and output hazards, a dependent read landing the cycle after its producer retires, a held result releasing right after the reader fetches, and the lower code winning a write-back tie.

// File: rtl/sbPkg.sv
package sbPkg;
  localparam int NUM_REGS  = 32;
  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int NUM_UNITS = 5;
  localparam int UNIT_W    = $clog2(NUM_UNITS + 1);

  typedef logic [REG_W-1:0]  regIdx_t;
  typedef logic [UNIT_W-1:0] unitId_t;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_DIV = 2'd3
  } opClass_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAITOPS,
    ST_EXEC,
    ST_DONE
  } unitState_t;

  // per-unit status record
  typedef struct packed {
    logic     busy;
    opClass_t op;
    regIdx_t  fi;
    regIdx_t  fj;
    regIdx_t  fk;
    unitId_t  qj;
    unitId_t  qk;
    logic     rj;
    logic     rk;
  } unitRec_t;

  // control -> datapath strobes
  typedef struct packed {
    logic                 issueFire;
    unitId_t              issueUnit;
    logic [NUM_UNITS-1:0] readGrant;
    logic [NUM_UNITS-1:0] wbGrant;
    logic                 wbFire;
    unitId_t              wbUnit;
  } sbStrobes_t;

  // unit index -> class served (index 0 int, 1 add, 2 div, 3..4 mul)
  function automatic opClass_t unitClass(input int idx);
    case (idx)
      0:       return CLS_INT;
      1:       return CLS_ADD;
      2:       return CLS_DIV;
      default: return CLS_MUL;
    endcase
  endfunction
endpackage

// File: rtl/sbControl.sv
module sbControl
  import sbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  opClass_t   instClass,
  input  unitId_t    dstOwner,
  input  unitRec_t   recs   [NUM_UNITS],
  input  unitState_t states [NUM_UNITS],
  output logic       instReady,
  output unitId_t    pickUnit,
  output sbStrobes_t strobes
);
  logic                 candFound;
  logic [NUM_UNITS-1:0] warHold;
  logic [NUM_UNITS-1:0] wbReq;

  // structural check: lowest free unit of the requested class
  always_comb begin
    candFound = 1'b0;
    pickUnit  = '0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (!candFound && !recs[i].busy && unitClass(i) == instClass) begin
        candFound = 1'b1;
        pickUnit  = unitId_t'(i + 1);
      end
    end
  end

  assign instReady = candFound && (dstOwner == '0);

  // WAR: another unit still has an unread source naming our destination
  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      warHold[i] = 1'b0;
      for (int j = 0; j < NUM_UNITS; j++) begin
        if (j != i && recs[j].busy &&
            ((recs[j].rj && recs[j].fj == recs[i].fi) ||
             (recs[j].rk && recs[j].fk == recs[i].fi)))
          warHold[i] = 1'b1;
      end
      wbReq[i] = (states[i] == ST_DONE) && !warHold[i];
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.issueFire = instValid && instReady;
    strobes.issueUnit = pickUnit;
    for (int i = 0; i < NUM_UNITS; i++)
      strobes.readGrant[i] = (states[i] == ST_WAITOPS) && recs[i].rj && recs[i].rk;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (wbReq[i]) begin
        strobes.wbGrant = '0;
        strobes.wbGrant[i] = 1'b1;
        strobes.wbUnit  = unitId_t'(i + 1);
        strobes.wbFire  = 1'b1;
      end
    end
  end

  assert_single_wb_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wbGrant));

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gChk
    assert_rec_class_R2: assert property (@(posedge clk) disable iff (!rstN)
      recs[g].busy |-> recs[g].op == unitClass(g));
    assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobes.readGrant[g] |-> (recs[g].qj == '0 && recs[g].qk == '0));
  end
endmodule

// File: rtl/sbDatapath.sv
module sbDatapath
  import sbPkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 6,
  parameter int LAT_DIV = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sbStrobes_t           strobes,
  input  opClass_t             instClass,
  input  regIdx_t              instDst,
  input  regIdx_t              instSrc1,
  input  regIdx_t              instSrc2,
  output unitId_t              dstOwner,
  output unitRec_t             recs   [NUM_UNITS],
  output unitState_t           states [NUM_UNITS],
  output logic [NUM_UNITS-1:0] execStart,
  output regIdx_t              wbReg
);
  localparam int MAX_LAT = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  unitId_t resultTable [NUM_REGS];
  unitId_t own1, own2, fwdQ1, fwdQ2;
  logic    warConflict;

  assign dstOwner = resultTable[instDst];
  assign own1     = resultTable[instSrc1];
  assign own2     = resultTable[instSrc2];
  // a producer retiring this very cycle counts as already written
  assign fwdQ1 = (strobes.wbFire && own1 == strobes.wbUnit) ? '0 : own1;
  assign fwdQ2 = (strobes.wbFire && own2 == strobes.wbUnit) ? '0 : own2;

  always_comb begin
    wbReg = '0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (strobes.wbGrant[i]) wbReg = recs[i].fi;
  end

  always_comb begin
    warConflict = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++)
      if (!strobes.wbGrant[i] && recs[i].busy &&
          ((recs[i].rj && recs[i].fj == wbReg) || (recs[i].rk && recs[i].fk == wbReg)))
        warConflict = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) resultTable[r] <= '0;
    end else begin
      if (strobes.wbFire)    resultTable[wbReg]   <= '0;
      if (strobes.issueFire) resultTable[instDst] <= strobes.issueUnit;
    end
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnit
    localparam int LAT = (g == 0) ? LAT_INT : (g == 1) ? LAT_ADD :
                         (g == 2) ? LAT_DIV : LAT_MUL;
    unitRec_t         recQ;
    unitState_t       stateQ;
    logic [CNT_W-1:0] cntQ;
    logic             startQ;
    logic             issueHere;

    assign issueHere = strobes.issueFire && strobes.issueUnit == unitId_t'(g + 1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        recQ   <= '0;
        stateQ <= ST_IDLE;
        cntQ   <= '0;
        startQ <= 1'b0;
      end else begin
        startQ <= strobes.readGrant[g];
        if (strobes.wbGrant[g]) begin
          recQ   <= '0;
          stateQ <= ST_IDLE;
        end else if (issueHere) begin
          recQ.busy <= 1'b1;
          recQ.op   <= instClass;
          recQ.fi   <= instDst;
          recQ.fj   <= instSrc1;
          recQ.fk   <= instSrc2;
          recQ.qj   <= fwdQ1;
          recQ.qk   <= fwdQ2;
          recQ.rj   <= (fwdQ1 == '0);
          recQ.rk   <= (fwdQ2 == '0);
          stateQ    <= ST_WAITOPS;
        end else begin
          if (strobes.readGrant[g]) begin
            recQ.rj <= 1'b0;
            recQ.rk <= 1'b0;
            stateQ  <= ST_EXEC;
            cntQ    <= CNT_W'(LAT);
          end else if (stateQ == ST_EXEC) begin
            if (cntQ == CNT_W'(1)) stateQ <= ST_DONE;
            else                   cntQ   <= cntQ - 1'b1;
          end
          if (strobes.wbFire && recQ.qj == strobes.wbUnit) begin
            recQ.qj <= '0;
            recQ.rj <= 1'b1;
          end
          if (strobes.wbFire && recQ.qk == strobes.wbUnit) begin
            recQ.qk <= '0;
            recQ.rk <= 1'b1;
          end
        end
      end
    end

    assign recs[g]      = recQ;
    assign states[g]    = stateQ;
    assign execStart[g] = startQ;

    assert_wb_from_done_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wbGrant[g] |-> stateQ == ST_DONE);
    assert_issue_free_R6: assert property (@(posedge clk) disable iff (!rstN)
      issueHere |-> !recQ.busy);
  end

  assert_waw_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueFire |-> dstOwner == '0);
  assert_war_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wbFire |-> !warConflict);
endmodule

// File: rtl/scoreboardCtl.sv
module scoreboardCtl
  import sbPkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 6,
  parameter int LAT_DIV = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic [1:0]           instClass,
  input  logic [REG_W-1:0]     instDst,
  input  logic [REG_W-1:0]     instSrc1,
  input  logic [REG_W-1:0]     instSrc2,
  output logic                 instReady,
  output logic [UNIT_W-1:0]    issueUnit,
  output logic [NUM_UNITS-1:0] readGrant,
  output logic [NUM_UNITS-1:0] execStart,
  output logic [NUM_UNITS-1:0] wbGrant,
  output logic [REG_W-1:0]     wbReg
);
  sbStrobes_t strobes;
  unitRec_t   recs   [NUM_UNITS];
  unitState_t states [NUM_UNITS];
  unitId_t    dstOwner;
  opClass_t   clsIn;

  assign clsIn = opClass_t'(instClass);

  sbControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .instClass(clsIn),
    .dstOwner (dstOwner),
    .recs     (recs),
    .states   (states),
    .instReady(instReady),
    .pickUnit (issueUnit),
    .strobes  (strobes)
  );

  sbDatapath #(
    .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .instClass(clsIn),
    .instDst  (instDst),
    .instSrc1 (instSrc1),
    .instSrc2 (instSrc2),
    .dstOwner (dstOwner),
    .recs     (recs),
    .states   (states),
    .execStart(execStart),
    .wbReg    (wbReg)
  );

  assign readGrant = strobes.readGrant;
  assign wbGrant   = strobes.wbGrant;
endmodule

// File: tb/tb_scoreboardCtl.sv
module tb_scoreboardCtl;
  localparam int NU = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid = 1'b0;
  logic [1:0] instClass = '0;
  logic [4:0] instDst = '0, instSrc1 = '0, instSrc2 = '0;
  logic       instReady;
  logic [2:0] issueUnit;
  logic [4:0] readGrant, execStart, wbGrant, wbReg;

  scoreboardCtl dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .instDst(instDst), .instSrc1(instSrc1), .instSrc2(instSrc2),
    .instReady(instReady), .issueUnit(issueUnit), .readGrant(readGrant),
    .execStart(execStart), .wbGrant(wbGrant), .wbReg(wbReg)
  );

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rdC[NU], exC[NU], wbC[NU], rdN[NU], exN[NU], wbN[NU], wbR[NU];
  int nChk = 0, nFail = 0;

  always @(negedge clk) begin
    if (rstN) begin
      for (int u = 0; u < NU; u++) begin
        if (readGrant[u]) begin rdC[u] = cyc; rdN[u]++; end
        if (execStart[u]) begin exC[u] = cyc; exN[u]++; end
        if (wbGrant[u])   begin wbC[u] = cyc; wbN[u]++; wbR[u] = int'(wbReg); end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0;
    instValid = 1'b0;
    repeat (2) @(negedge clk);
    for (int u = 0; u < NU; u++) begin
      rdC[u] = -1; exC[u] = -1; wbC[u] = -1;
      rdN[u] = 0;  exN[u] = 0;  wbN[u] = 0; wbR[u] = -1;
    end
    rstN = 1'b1;
  endtask

  task automatic send(input int c, input int d, input int s1, input int s2,
                      output int ic, output int code);
    @(negedge clk);
    instClass = 2'(c); instDst = 5'(d); instSrc1 = 5'(s1); instSrc2 = 5'(s2);
    instValid = 1'b1;
    #1;
    while (!instReady) begin
      @(negedge clk);
      #1;
    end
    ic   = cyc;
    code = int'(issueUnit);
    @(posedge clk);
    #1 instValid = 1'b0;
  endtask

  task automatic drain;
    repeat (30) @(negedge clk);
  endtask

  function automatic int expCode(input int c);
    case (c) 0: return 1; 1: return 2; 2: return 4; default: return 3; endcase
  endfunction

  function automatic int expLat(input int c);
    case (c) 0: return 1; 1: return 4; 2: return 6; default: return 10; endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog (R1..): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int a, b, c, ua, ub, uc, u;

    // R1: reset state
    doReset();
    @(negedge clk); #1;
    chk("R1 instReady", int'(instReady), 1);
    chk("R1 readGrant", int'(readGrant), 0);
    chk("R1 execStart", int'(execStart), 0);
    chk("R1 wbGrant", int'(wbGrant), 0);

    // R2, R3, R9: sweep every destination over all classes
    for (int d = 0; d < 32; d++) begin
      int cls = d % 4;
      doReset();
      send(cls, d, (d + 1) % 32, (d + 2) % 32, a, ua);
      drain();
      chk("R2 unit code", ua, expCode(cls));
      u = ua - 1;
      if (u < 0 || u >= NU) u = 0;
      chk("R3 read cycle", rdC[u] - a, 1);
      chk("R3 exec start", exC[u] - rdC[u], 1);
      chk("R3 write-back latency", wbC[u] - rdC[u], expLat(cls) + 1);
      chk("R3 wbReg", wbR[u], d);
      chk("R9 reads", rdN[u], 1);
      chk("R9 starts", exN[u], 1);
      chk("R9 writes", wbN[u], 1);
    end

    // R2, R6: multipliers 4 then 5, a third waits for unit 4
    doReset();
    send(2, 1, 2, 3, a, ua);
    send(2, 4, 5, 6, b, ub);
    send(2, 7, 8, 9, c, uc);
    chk("R2 first mul", ua, 4);
    chk("R2 second mul", ub, 5);
    chk("R6 third mul unit", uc, 4);
    chk("R6 third mul issue", c, wbC[3] + 1);
    drain();
    chk("R9 mul4 writes", wbN[3], 2);

    // R6: adder busy
    doReset();
    send(1, 10, 1, 2, a, ua);
    send(1, 11, 3, 4, b, ub);
    chk("R6 second add issue", b, wbC[1] + 1);
    drain();

    // R4: RAW through second source and through first source
    doReset();
    send(3, 5, 1, 2, a, ua);
    send(1, 6, 7, 5, b, ub);
    drain();
    chk("R4 src2 dependent read", rdC[1], wbC[2] + 1);
    chk("R3 dependent add wb", wbC[1] - rdC[1], 5);
    doReset();
    send(2, 9, 1, 2, a, ua);
    send(0, 10, 9, 11, b, ub);
    drain();
    chk("R4 src1 dependent read", rdC[0], wbC[3] + 1);

    // R4: consumer issues in the producer's write-back cycle
    doReset();
    send(0, 12, 1, 2, a, ua);
    repeat (2) @(negedge clk);
    send(1, 13, 12, 12, b, ub);
    drain();
    chk("R4 same-cycle issue", b, wbC[0]);
    chk("R4 same-cycle read", rdC[1], b + 1);

    // R5: output dependence stalls issue
    doReset();
    send(3, 4, 1, 2, a, ua);
    send(1, 4, 1, 2, b, ub);
    chk("R5 waw issue", b, wbC[2] + 1);
    drain();
    chk("R5 waw second wb", wbR[1], 4);

    // R7: write-after-read hold
    doReset();
    send(3, 0, 2, 4, a, ua);
    send(1, 10, 0, 8, b, ub);
    send(2, 8, 8, 14, c, uc);
    drain();
    chk("R7 reader waits on div", rdC[1], wbC[2] + 1);
    chk("R7 mul reads early", rdC[3], c + 1);
    begin
      int e = rdC[3] + 7;
      if (rdC[1] + 1 > e) e = rdC[1] + 1;
      chk("R7 held write-back", wbC[3], e);
    end

    // R8: two finish together, lower code first
    doReset();
    send(2, 20, 1, 2, a, ua);
    @(negedge clk);
    send(1, 21, 3, 4, b, ub);
    drain();
    chk("R8 add wb", wbC[1], b + 6);
    chk("R8 mul wb", wbC[3], (a + 8 == b + 6) ? a + 9 : a + 8);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule